// File: doc/BRIEF.md
# Power-Stage Fault Latch Controller

This block sits between the protection comparators of a four-channel switching power stage and the gate-drive enables. For each output channel it decides whether that half-bridge must be held at high impedance, and it produces the report pins that system logic reads to learn why. Channels are grouped in two pairs. Each pair has its own active-low reset that also puts its two channels into high impedance while it is held low.

Faults are latched. An over-current flag disables only the channel that raised it and is reported on the output for its pair. A thermal error or a supply under-voltage disables every channel and is reported on a shared output. A thermal warning is reported on its own output without disabling anything. A latched fault clears only after the condition has gone away and the relevant pair reset has then produced a low-to-high edge. A global fault needs such an edge on both pair resets. Every comparator and reset input passes through a two-flop synchronizer first. A change on an input therefore reaches the outputs at the third rising clock edge after it.

All report outputs are active low and model open-drain drivers: a value of 0 means the pin is pulled low and a value of 1 means it is released.

Top module: `pfl_ctrl`

## Requirements
- R1: Channels 0 and 1 report over-current on `oc_rpt_n_o[0]` and channels 2 and 3 report on `oc_rpt_n_o[1]`. Each bit is 0 while either channel of its pair has a latched over-current, and 1 otherwise.
- R2: An over-current on channel c sets `hiz_o[c]` to 1 and leaves the other channels' `hiz_o` bits unchanged.
- R3: A rising edge on a pair reset while the over-current condition of a channel in that pair is still present does not clear that channel's latch.
- R4: Removing the over-current condition alone does not clear the latch. The latch clears on the first rising edge of the pair reset that occurs while the condition is absent.
- R5: `warn_n_o` is 0 exactly while the synchronized thermal warning input is 1. The warning is not latched and has no effect on `hiz_o`.
- R6: A thermal error or an under-voltage sets `glob_rpt_n_o` to 0 and sets all four `hiz_o` bits to 1.
- R7: The global fault stays latched after its condition is removed. It clears only once both pair resets have each produced a rising edge while the condition is absent. One pair's edge alone does not clear it, and edges that occur while the condition is present do not count toward clearing.
- R8: While `pair_rst_ni[p]` is 0, both channels of pair p have `hiz_o` set to 1. When the pair reset is released and no fault is latched, those channels are enabled again.
- R9: The pair {`warn_n_o`, `glob_rpt_n_o`} encodes the status as follows: 00 means warning plus thermal error and/or under-voltage, 01 means warning only, 10 means thermal error or under-voltage without warning, and 11 means normal.
- R10: Every input takes effect on the outputs at the third rising clock edge after it changes, and not at the second.
- R11: While `rst_ni` is 0, `hiz_o` is 4'hF, and `oc_rpt_n_o`, `glob_rpt_n_o` and `warn_n_o` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oc_i | input | 4 | Over-current flag per channel, active high |
| therm_warn_i | input | 1 | Thermal warning comparator, active high |
| therm_err_i | input | 1 | Thermal error comparator, active high |
| uv_i | input | 1 | Supply under-voltage comparator, active high |
| pair_rst_ni | input | 2 | Active-low pair resets (bit 0: channels 0/1, bit 1: channels 2/3) |
| hiz_o | output | 4 | High-impedance request per channel |
| oc_rpt_n_o | output | 2 | Over-current report per pair, 0 = pulled low |
| glob_rpt_n_o | output | 1 | Thermal error / under-voltage report, 0 = pulled low |
| warn_n_o | output | 1 | Thermal warning report, 0 = pulled low |

## Verification
Over-current is applied on a single channel in each pair and then on one channel of each pair at once. These cases separate the per-pair report mapping from the per-channel disable. Clearing is tried with the condition removed but no reset edge, with a reset edge while the condition persists, and with an edge after the condition is gone, so that both clearing conditions are shown to be required. The global fault is released with one pair edge, then the second, and separately with edges taken during the fault. Warning, under-voltage and thermal error are combined to walk all four report encodings. Checks at the second and third edge after a change pin down the synchronizer latency.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int unsigned PFL_PAIRS_DEF = 2;
  localparam int unsigned PFL_CPP_DEF   = 2;
  localparam int unsigned PFL_SYNC_DEF  = 2;

  function automatic int unsigned pair_of(input int unsigned ch, input int unsigned cpp);
    return ch / cpp;
  endfunction
endpackage

// File: rtl/pfl_sync.sv
module pfl_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pfl_pair_rst.sv
module pfl_pair_rst #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pair_rst_ni,
  output logic en_o,
  output logic rise_o
);
  logic rel_s;
  logic en_q;

  pfl_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pair_rst_ni),
    .q_o    (rel_s)
  );

  // en_q doubles as the previous-value flop for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= rel_s;
  end

  assign rise_o = rel_s & ~en_q;
  assign en_o   = en_q;

  AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R8
  AST_EN_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> en_o); // R8
endmodule

// File: rtl/pfl_oc_latch.sv
module pfl_oc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic rise_i,
  output logic lat_o
);
  logic lat_q;

  // set dominates; clear needs edge with condition absent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= 1'b0;
    else         lat_q <= cond_i | (lat_q & ~(rise_i & ~cond_i));
  end

  assign lat_o = lat_q;

  AST_OC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i |=> lat_q); // R2
  AST_OC_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !rise_i) |=> lat_q); // R4
  AST_OC_HOLD_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && cond_i) |=> lat_q); // R3
  AST_OC_CLEAR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lat_q) |-> ($past(rise_i) && !$past(cond_i))); // R4
endmodule

// File: rtl/pfl_glob_latch.sv
module pfl_glob_latch #(
  parameter int unsigned PAIRS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cond_i,
  input  logic [PAIRS-1:0] rise_i,
  output logic             lat_o
);
  logic             lat_q, lat_d;
  logic [PAIRS-1:0] arm_q, arm_d;

  always_comb begin
    if (cond_i || !lat_q) arm_d = '0;
    else                  arm_d = arm_q | rise_i;
    lat_d = cond_i | (lat_q & ~(&arm_d));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      arm_q <= '0;
    end else begin
      lat_q <= lat_d;
      arm_q <= lat_d ? arm_d : '0;
    end
  end

  assign lat_o = lat_q;

  AST_GLOB_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i |=> lat_q); // R6
  AST_GLOB_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lat_q) |-> !$past(cond_i)); // R7
  AST_GLOB_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && rise_i == '0) |=> lat_q); // R7
endmodule

// File: rtl/pfl_ctrl.sv
module pfl_ctrl #(
  parameter int unsigned N_PAIRS     = pfl_pkg::PFL_PAIRS_DEF,
  parameter int unsigned CH_PER_PAIR = pfl_pkg::PFL_CPP_DEF,
  parameter int unsigned SYNC_STAGES = pfl_pkg::PFL_SYNC_DEF
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_PAIRS*CH_PER_PAIR-1:0]   oc_i,
  input  logic                             therm_warn_i,
  input  logic                             therm_err_i,
  input  logic                             uv_i,
  input  logic [N_PAIRS-1:0]               pair_rst_ni,
  output logic [N_PAIRS*CH_PER_PAIR-1:0]   hiz_o,
  output logic [N_PAIRS-1:0]               oc_rpt_n_o,
  output logic                             glob_rpt_n_o,
  output logic                             warn_n_o
);
  localparam int unsigned N_CH   = N_PAIRS * CH_PER_PAIR;
  localparam int unsigned COND_W = N_CH + 3;

  logic [COND_W-1:0]  cond_s;
  logic [N_CH-1:0]    oc_s;
  logic               warn_s, terr_s, uv_s;
  logic [N_PAIRS-1:0] pair_en, pair_rise;
  logic [N_CH-1:0]    oc_lat;
  logic               glob_lat;
  logic               warn_q;

  pfl_sync #(.W(COND_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_cond_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({uv_i, therm_err_i, therm_warn_i, oc_i}),
    .q_o    (cond_s)
  );

  assign oc_s   = cond_s[N_CH-1:0];
  assign warn_s = cond_s[N_CH];
  assign terr_s = cond_s[N_CH+1];
  assign uv_s   = cond_s[N_CH+2];

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    pfl_pair_rst #(.STAGES(SYNC_STAGES)) u_prst (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pair_rst_ni (pair_rst_ni[p]),
      .en_o        (pair_en[p]),
      .rise_o      (pair_rise[p])
    );

    assign oc_rpt_n_o[p] = ~|oc_lat[p*CH_PER_PAIR +: CH_PER_PAIR];

    AST_RPT_IMPLIES_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oc_rpt_n_o[p] |-> |hiz_o[p*CH_PER_PAIR +: CH_PER_PAIR]); // R1
    AST_PAIR_OFF_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pair_en[p] |-> &hiz_o[p*CH_PER_PAIR +: CH_PER_PAIR]); // R8
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned PIDX = pfl_pkg::pair_of(c, CH_PER_PAIR);

    pfl_oc_latch u_oc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cond_i (oc_s[c]),
      .rise_i (pair_rise[PIDX]),
      .lat_o  (oc_lat[c])
    );

    assign hiz_o[c] = oc_lat[c] | glob_lat | ~pair_en[PIDX];
  end

  pfl_glob_latch #(.PAIRS(N_PAIRS)) u_glob (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (terr_s | uv_s),
    .rise_i (pair_rise),
    .lat_o  (glob_lat)
  );

  // register keeps warning latency equal to the fault paths
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warn_q <= 1'b0;
    else         warn_q <= warn_s;
  end

  assign warn_n_o     = ~warn_q;
  assign glob_rpt_n_o = ~glob_lat;

  AST_GLOB_ALL_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_rpt_n_o |-> &hiz_o); // R6
  AST_WARN_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_s |=> !warn_n_o); // R5
endmodule

// File: tb/pfl_ctrl_tb.sv
module pfl_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] oc = '0;
  logic       tw = 1'b0, te = 1'b0, uv = 1'b0;
  logic [1:0] prst = 2'b00;
  logic [3:0] hiz;
  logic [1:0] ocr;
  logic       gr, wr;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    string      tag;
    logic [3:0] hiz;
    logic [1:0] ocr;
    logic       g;
    logic       w;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfl_ctrl u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .oc_i         (oc),
    .therm_warn_i (tw),
    .therm_err_i  (te),
    .uv_i         (uv),
    .pair_rst_ni  (prst),
    .hiz_o        (hiz),
    .oc_rpt_n_o   (ocr),
    .glob_rpt_n_o (gr),
    .warn_n_o     (wr)
  );

  task automatic compare(input exp_t e);
    n_run++;
    if (hiz !== e.hiz || ocr !== e.ocr || gr !== e.g || wr !== e.w) begin
      n_fail++;
      $display("FAIL %s: act hiz=%b ocr=%b g=%b w=%b exp hiz=%b ocr=%b g=%b w=%b",
               e.tag, hiz, ocr, gr, wr, e.hiz, e.ocr, e.g, e.w);
    end
  endtask

  // monitor: pops expected items when their cycle comes
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      compare(q.pop_front());
    end
  end

  task automatic apply(input logic [3:0] o, input logic w, input logic e,
                       input logic u, input logic [1:0] r);
    @(posedge clk);
    #2;
    oc = o; tw = w; te = e; uv = u; prst = r;
  endtask

  task automatic expect_at(input int off, input string tag, input logic [3:0] h,
                           input logic [1:0] o, input logic g, input logic w);
    exp_t e;
    e.due = cyc + off; e.tag = tag; e.hiz = h; e.ocr = o; e.g = g; e.w = w;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act running exp finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t r0;
    idle(3);
    #3;
    r0.due = 0; r0.tag = "R11 reset state"; r0.hiz = 4'hF; r0.ocr = 2'b11; r0.g = 1'b1; r0.w = 1'b1;
    compare(r0);
    @(negedge clk);
    rst_n = 1'b1;

    // release pair resets
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(2, "R10 pair release not yet", 4'hF, 2'b11, 1, 1);
    expect_at(3, "R8 pairs enabled", 4'h0, 2'b11, 1, 1);
    idle(4);

    // R1/R2: over-current on channel 0
    apply(4'h1, 0, 0, 0, 2'b11);
    expect_at(2, "R10 oc not yet", 4'h0, 2'b11, 1, 1);
    expect_at(3, "R2 ch0 oc hiz", 4'h1, 2'b10, 1, 1);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R4 removal alone keeps latch", 4'h1, 2'b10, 1, 1);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b10);
    expect_at(3, "R8 pair0 low hiz", 4'h3, 2'b10, 1, 1);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R4 edge clears ch0", 4'h0, 2'b11, 1, 1);
    idle(4);

    // R3: channel 3 over-current held through an edge
    apply(4'h8, 0, 0, 0, 2'b11);
    expect_at(3, "R1 ch3 reports on pair1", 4'h8, 2'b01, 1, 1);
    idle(4);
    apply(4'h8, 0, 0, 0, 2'b01);
    expect_at(3, "R8 pair1 low", 4'hC, 2'b01, 1, 1);
    idle(4);
    apply(4'h8, 0, 0, 0, 2'b11);
    expect_at(3, "R3 edge during oc keeps latch", 4'h8, 2'b01, 1, 1);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b01);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R4 ch3 cleared", 4'h0, 2'b11, 1, 1);
    idle(4);

    // R5/R9: warning only, not latched
    apply(4'h0, 1, 0, 0, 2'b11);
    expect_at(2, "R10 warn not yet", 4'h0, 2'b11, 1, 1);
    expect_at(3, "R5 R9 warning only", 4'h0, 2'b11, 1, 0);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R5 warning not latched", 4'h0, 2'b11, 1, 1);
    idle(4);

    // R6/R9: under-voltage only, then warning plus thermal error
    apply(4'h0, 0, 0, 1, 2'b11);
    expect_at(3, "R6 R9 uv all hiz", 4'hF, 2'b11, 0, 1);
    idle(4);
    apply(4'h0, 1, 1, 0, 2'b11);
    expect_at(3, "R9 warn plus error", 4'hF, 2'b11, 0, 0);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R7 latched after removal", 4'hF, 2'b11, 0, 1);
    idle(4);

    // R7: one pair edge is not enough
    apply(4'h0, 0, 0, 0, 2'b10);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R7 one pair edge only", 4'hF, 2'b11, 0, 1);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b01);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R7 second pair edge clears", 4'h0, 2'b11, 1, 1);
    idle(4);

    // R7: edges during the condition do not count
    apply(4'h0, 0, 0, 1, 2'b11);
    expect_at(3, "R6 uv again", 4'hF, 2'b11, 0, 1);
    idle(4);
    apply(4'h0, 0, 0, 1, 2'b00);
    idle(4);
    apply(4'h0, 0, 0, 1, 2'b11);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R7 edges during fault ignored", 4'hF, 2'b11, 0, 1);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b00);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R7 both edges clear", 4'h0, 2'b11, 1, 1);
    idle(4);

    // R1/R2: one channel in each pair
    apply(4'h6, 0, 0, 0, 2'b11);
    expect_at(3, "R1 R2 ch1 and ch2", 4'h6, 2'b00, 1, 1);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b00);
    idle(4);
    apply(4'h0, 0, 0, 0, 2'b11);
    expect_at(3, "R4 both pairs cleared", 4'h0, 2'b11, 1, 1);
    idle(5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule